// File: doc/BRIEF.md
# Security-Level PMP Access Checker

This block decides whether one memory access may proceed under a physical memory protection scheme. The scheme has four global security levels. It takes a word address, an access kind, the effective privilege and the status bits that affect data accesses made on behalf of a lower privilege. It compares the address against a configurable set of protection entries in parallel. The matching entry with the lowest index decides the result. That entry's two-bit privilege field, together with the current level, selects which of its read/write/execute bits apply to machine mode and which apply to supervisor/user mode. When no entry matches, a default rule applies. Under this rule machine mode loses execute permission at the two highest levels, and a closed-default bit can deny everything.

The entry configuration and addresses arrive as plain vectors from a register file outside the block. The block only evaluates them. Each valid request produces one registered verdict (allow or access fault), a hit flag and the index of the deciding entry, one cycle later.

Top module: `pmp_lvl_checker`

## Requirements
- R1: A request presented with `req_valid_i` high yields `rsp_valid_o` high on the next clock together with its verdict, hit flag and index. Without a request, `rsp_valid_o` is low the following cycle and the other outputs keep their values. After reset all outputs are 0.
- R2: When several entries match, only the lowest-indexed one decides. `rsp_hit_o` is 1 and `rsp_idx_o` carries its index. With no match, `rsp_hit_o` is 0 and `rsp_idx_o` is 0.
- R3: Each entry's configuration is 7 bits: [2:0] permissions (bit 0 read, bit 1 write, bit 2 execute), [4:3] matching mode and [6:5] privilege field. Matching modes: 0 never matches; 1 matches words from the previous entry's address (0 for entry 0) up to, but excluding, its own; 2 matches its single word; 3 matches an aligned block whose size is 2^(k+1) words, where k is the number of trailing ones in the entry address.
- R4: At level 0, a privilege field of 0 or 1 gives machine mode every access and applies the permission bits to supervisor/user. A field of 2 or 3 applies the permission bits to both privileges.
- R5: At levels 1 to 3, privilege field 0 gives machine mode read and write but no execute, and applies the permission bits to supervisor/user.
- R6: At levels 1 to 3, privilege field 1 denies every machine-mode access and applies the permission bits to supervisor/user.
- R7: At levels 1 to 3, privilege field 2 or 3 applies the permission bits to machine mode and denies every supervisor/user access.
- R8: With no match and the closed-default bit 0, machine mode gets every access at levels 0 and 1, and read and write only at levels 2 and 3. Supervisor/user is always denied.
- R9: With no match and the closed-default bit 1, every access faults. The bit has no effect on a matched access.
- R10: For a machine-mode read with `mxr_i`=1, `mprv_i`=1 and `mpp_i` not 3, a matched entry whose supervisor/user permissions include execute also grants the read. If any of the three conditions is absent, no read is granted this way. Writes are never granted this way.
- R11: The access kind is encoded 0 read, 1 write, 2 execute. The value 3 always faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe |
| req_word_addr_i | input | ADDR_W-2 | Word address of the access |
| req_kind_i | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| req_priv_m_i | input | 1 | Effective privilege is machine mode |
| mxr_i | input | 1 | Make-executable-readable status bit |
| mprv_i | input | 1 | Modify-privilege status bit |
| mpp_i | input | 2 | Previous-privilege field (3 = machine) |
| sec_level_i | input | 2 | Global security level 0..3 |
| dflt_closed_i | input | 1 | Deny accesses that match no entry |
| entry_cfg_i | input | NUM_ENTRIES x 7 | Per-entry permissions, matching mode, privilege field |
| entry_addr_i | input | NUM_ENTRIES x (ADDR_W-2) | Per-entry word address |
| rsp_valid_o | output | 1 | Verdict strobe, one cycle after request |
| rsp_allow_o | output | 1 | 1 = allow, 0 = access fault |
| rsp_hit_o | output | 1 | An entry matched |
| rsp_idx_o | output | IDX_W | Index of the deciding entry |

## Verification
Every verdict, hit flag and index passes through exactly one register. Each result is therefore due on the clock edge after the request is driven. The bench drives inputs on a falling edge and reads the outputs on the next falling edge. It keeps the request strobe high across consecutive vectors, so every vector is checked exactly one cycle behind its stimulus. For the idle case, the strobe is dropped for one cycle. At the next falling edge the bench expects `rsp_valid_o` low and the previous verdict and index unchanged.

// File: rtl/pmp_lvl_pkg.sv
package pmp_lvl_pkg;

  typedef enum logic [1:0] {
    MM_OFF   = 2'd0,
    MM_TOR   = 2'd1,
    MM_NA4   = 2'd2,
    MM_NAPOT = 2'd3
  } match_mode_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;
  localparam int CFG_W  = 7;

  typedef struct packed {
    logic [1:0]  plk;
    logic [1:0]  mode;
    logic [2:0]  perm;
  } entry_cfg_t;

endpackage

// File: rtl/pmp_lvl_match.sv
module pmp_lvl_match #(
  parameter int WA_W = 30
) (
  input  logic [WA_W-1:0] req_wa_i,
  input  logic [WA_W-1:0] base_i,
  input  logic [WA_W-1:0] addr_i,
  input  logic [1:0]      mode_i,
  output logic            hit_o
);
  import pmp_lvl_pkg::*;

  logic [WA_W-1:0] napot_care;

  // Trailing ones plus the next zero bit are "don't care" positions.
  assign napot_care = ~(addr_i ^ (addr_i + {{(WA_W-1){1'b0}}, 1'b1}));

  always_comb begin
    unique case (mode_i)
      MM_TOR:   hit_o = (req_wa_i >= base_i) && (req_wa_i < addr_i);
      MM_NA4:   hit_o = (req_wa_i == addr_i);
      MM_NAPOT: hit_o = ((req_wa_i & napot_care) == (addr_i & napot_care));
      default:  hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmp_lvl_perm.sv
module pmp_lvl_perm (
  input  logic [1:0] level_i,
  input  logic       hit_i,
  input  logic [1:0] plk_i,
  input  logic [2:0] perm_i,
  input  logic       priv_m_i,
  input  logic       mxr_i,
  input  logic       mprv_i,
  input  logic [1:0] mpp_i,
  input  logic [1:0] kind_i,
  input  logic       closed_i,
  output logic       allow_o
);
  import pmp_lvl_pkg::*;

  logic [2:0] m_perm;
  logic [2:0] su_perm;
  logic [2:0] eff;
  logic       mxr_grant;

  always_comb begin
    if (!hit_i) begin
      su_perm = 3'b000;
      if (closed_i)          m_perm = 3'b000;
      else if (level_i < 2)  m_perm = 3'b111;
      else                   m_perm = 3'b011;
    end else if (level_i == 2'd0) begin
      su_perm = perm_i;
      m_perm  = plk_i[1] ? perm_i : 3'b111;
    end else begin
      unique case (plk_i)
        2'd0:    begin m_perm = 3'b011; su_perm = perm_i; end
        2'd1:    begin m_perm = 3'b000; su_perm = perm_i; end
        default: begin m_perm = perm_i; su_perm = 3'b000; end
      endcase
    end
  end

  assign mxr_grant = hit_i && priv_m_i && mxr_i && mprv_i && (mpp_i != 2'd3)
                     && su_perm[PERM_X];

  always_comb begin
    eff = priv_m_i ? m_perm : su_perm;
    if (mxr_grant) eff[PERM_R] = 1'b1;
  end

  always_comb begin
    unique case (kind_i)
      ACC_READ:  allow_o = eff[PERM_R];
      ACC_WRITE: allow_o = eff[PERM_W];
      ACC_EXEC:  allow_o = eff[PERM_X];
      default:   allow_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmp_lvl_checker.sv
module pmp_lvl_checker #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  localparam int WA_W       = ADDR_W - 2,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                                   clk_i,
  input  logic                                   rst_i,
  input  logic                                   req_valid_i,
  input  logic [WA_W-1:0]                        req_word_addr_i,
  input  logic [1:0]                             req_kind_i,
  input  logic                                   req_priv_m_i,
  input  logic                                   mxr_i,
  input  logic                                   mprv_i,
  input  logic [1:0]                             mpp_i,
  input  logic [1:0]                             sec_level_i,
  input  logic                                   dflt_closed_i,
  input  logic [NUM_ENTRIES-1:0][6:0]            entry_cfg_i,
  input  logic [NUM_ENTRIES-1:0][WA_W-1:0]       entry_addr_i,
  output logic                                   rsp_valid_o,
  output logic                                   rsp_allow_o,
  output logic                                   rsp_hit_o,
  output logic [IDX_W-1:0]                       rsp_idx_o
);
  import pmp_lvl_pkg::*;

  logic [NUM_ENTRIES-1:0] hit_vec;
  logic                   any_hit;
  logic [IDX_W-1:0]       win_idx;
  entry_cfg_t             win_cfg;
  logic                   allow_c;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    entry_cfg_t      cfg;
    logic [WA_W-1:0] base;
    assign cfg = entry_cfg_t'(entry_cfg_i[g]);
    if (g == 0) begin : g_first
      assign base = '0;
    end else begin : g_rest
      assign base = entry_addr_i[g-1];
    end
    pmp_lvl_match #(.WA_W(WA_W)) match_i (
      .req_wa_i (req_word_addr_i),
      .base_i   (base),
      .addr_i   (entry_addr_i[g]),
      .mode_i   (cfg.mode),
      .hit_o    (hit_vec[g])
    );
  end

  // Lowest index wins: scan from the top so the smallest match is left last.
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end

  assign win_cfg = entry_cfg_t'(entry_cfg_i[win_idx]);

  pmp_lvl_perm perm_i (
    .level_i  (sec_level_i),
    .hit_i    (any_hit),
    .plk_i    (win_cfg.plk),
    .perm_i   (win_cfg.perm),
    .priv_m_i (req_priv_m_i),
    .mxr_i    (mxr_i),
    .mprv_i   (mprv_i),
    .mpp_i    (mpp_i),
    .kind_i   (req_kind_i),
    .closed_i (dflt_closed_i),
    .allow_o  (allow_c)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rsp_valid_o <= 1'b0;
      rsp_allow_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_idx_o   <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_allow_o <= allow_c;
        rsp_hit_o   <= any_hit;
        rsp_idx_o   <= win_idx;
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    req_valid_i |=> rsp_valid_o);

  assert_idle_holds_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    !req_valid_i |=> (!rsp_valid_o && $stable(rsp_allow_o) && $stable(rsp_idx_o)));

  assert_entry0_wins_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_valid_i && hit_vec[0]) |=> (rsp_hit_o && rsp_idx_o == '0));

  assert_closed_default_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_valid_i && dflt_closed_i && !any_hit) |=> (!rsp_allow_o && !rsp_hit_o));

  assert_su_excluded_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_valid_i && any_hit && sec_level_i != 2'd0 && win_cfg.plk[1] && !req_priv_m_i)
    |=> !rsp_allow_o);

  assert_dflt_noexec_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_valid_i && !any_hit && sec_level_i >= 2'd2 && req_priv_m_i
     && req_kind_i == ACC_EXEC) |=> !rsp_allow_o);

  assert_rsvd_kind_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_valid_i && req_kind_i == ACC_RSVD) |=> !rsp_allow_o);

endmodule

// File: tb/pmp_lvl_checker_tb_top.sv
module pmp_lvl_checker_tb_top;

  localparam int N    = 8;
  localparam int AW   = 32;
  localparam int WA_W = AW - 2;
  localparam int IW   = 3;
  localparam int NV   = 33;

  typedef struct packed {
    logic [3:0]      req;
    logic [1:0]      lvl;
    logic            pm;
    logic [1:0]      acc;
    logic [WA_W-1:0] wa;
    logic            cl;
    logic            mxr;
    logic            mprv;
    logic [1:0]      mpp;
    logic            ea;
    logic            eh;
    logic [IW-1:0]   ei;
  } vec_t;

  function automatic vec_t mk(int req, int lvl, int pm, int acc, int wa, int cl,
                              int mxr, int mprv, int mpp, int ea, int eh, int ei);
    vec_t v;
    v.req = 4'(req);  v.lvl = 2'(lvl);  v.pm = 1'(pm);    v.acc = 2'(acc);
    v.wa  = WA_W'(wa); v.cl = 1'(cl);   v.mxr = 1'(mxr);  v.mprv = 1'(mprv);
    v.mpp = 2'(mpp);  v.ea = 1'(ea);    v.eh = 1'(eh);    v.ei = IW'(ei);
    return v;
  endfunction

  // Fields: req, level, M?, kind, word addr, closed, mxr, mprv, mpp, exp allow, exp hit, exp idx
  localparam vec_t VECS [NV] = '{
    mk(2, 0,1,0,'h100, 0,0,0,0, 1,1,0),  // R2 entry0 over entry3, R4 field 2 read
    mk(4, 0,1,1,'h100, 0,0,0,0, 0,1,0),  // R4 field 2 applies bits to M
    mk(4, 0,0,0,'h100, 0,0,0,0, 1,1,0),  // R4
    mk(4, 0,1,2,'h205, 0,0,0,0, 1,1,1),  // R4 field 0: M all
    mk(4, 0,0,1,'h205, 0,0,0,0, 0,1,1),  // R4 S/U bits
    mk(5, 1,1,2,'h205, 0,0,0,0, 0,1,1),  // R5 no M execute
    mk(5, 1,1,1,'h205, 0,0,0,0, 1,1,1),  // R5 M write
    mk(5, 1,0,2,'h205, 0,0,0,0, 1,1,1),  // R5 S/U bits, R2 entry1 over entry2
    mk(6, 2,1,0,'h250, 0,0,0,0, 0,1,2),  // R6 M denied
    mk(6, 2,0,1,'h250, 0,0,0,0, 1,1,2),  // R6 S/U bits
    mk(7, 3,1,2,'h500, 0,0,0,0, 1,1,5),  // R7 M bits
    mk(7, 3,0,2,'h500, 0,0,0,0, 0,1,5),  // R7 S/U denied
    mk(4, 0,1,0,'h500, 0,0,0,0, 0,1,5),  // R4 field 3 at level 0
    mk(4, 0,0,2,'h500, 0,0,0,0, 1,1,5),  // R4
    mk(3, 3,1,0,'h10A, 0,0,0,0, 1,1,3),  // R3 NAPOT interior
    mk(5, 3,1,2,'h10A, 0,0,0,0, 0,1,3),  // R5
    mk(3, 0,1,2,'h400, 0,0,0,0, 1,0,0),  // R3 OFF entry never hits, R8
    mk(8, 1,1,2,'h400, 0,0,0,0, 1,0,0),  // R8
    mk(8, 2,1,2,'h400, 0,0,0,0, 0,0,0),  // R8 no default execute
    mk(8, 2,1,1,'h400, 0,0,0,0, 1,0,0),  // R8
    mk(8, 3,0,0,'h400, 0,0,0,0, 0,0,0),  // R8 S/U denied
    mk(9, 0,1,0,'h400, 1,0,0,0, 0,0,0),  // R9 closed default
    mk(3, 0,1,0,'h208, 0,0,0,0, 1,1,2),  // R3 past NAPOT end, inside TOR
    mk(3, 0,0,0,'h2FF, 0,0,0,0, 0,1,2),  // R3 TOR last word
    mk(3, 0,0,2,'h300, 0,0,0,0, 0,0,0),  // R3 TOR top exclusive
    mk(10,2,1,0,'h250, 0,1,1,0, 1,1,2),  // R10 grant
    mk(10,2,1,0,'h250, 0,1,1,3, 0,1,2),  // R10 mpp machine
    mk(10,2,1,0,'h250, 0,1,0,1, 0,1,2),  // R10 mprv clear
    mk(10,2,1,1,'h250, 0,1,1,0, 0,1,2),  // R10 write not granted
    mk(9, 2,0,1,'h250, 1,0,0,0, 1,1,2),  // R9 no effect on a match
    mk(11,0,1,3,'h400, 0,0,0,0, 0,0,0),  // R11 reserved kind
    mk(11,0,0,3,'h205, 0,0,0,0, 0,1,1),  // R11
    mk(3, 0,0,1,'h101, 0,0,0,0, 1,1,3)   // R3 NA4 is one word only
  };

  logic clk = 1'b0;
  logic rst;
  logic req_valid;
  logic [WA_W-1:0] req_wa;
  logic [1:0] req_kind;
  logic req_pm, mxr, mprv;
  logic [1:0] mpp, level;
  logic closed;
  logic [N-1:0][6:0]      cfg;
  logic [N-1:0][WA_W-1:0] eaddr;
  logic rsp_valid, rsp_allow, rsp_hit;
  logic [IW-1:0] rsp_idx;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pmp_lvl_checker #(.NUM_ENTRIES(N), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_i(rst), .req_valid_i(req_valid), .req_word_addr_i(req_wa),
    .req_kind_i(req_kind), .req_priv_m_i(req_pm), .mxr_i(mxr), .mprv_i(mprv),
    .mpp_i(mpp), .sec_level_i(level), .dflt_closed_i(closed),
    .entry_cfg_i(cfg), .entry_addr_i(eaddr),
    .rsp_valid_o(rsp_valid), .rsp_allow_o(rsp_allow), .rsp_hit_o(rsp_hit),
    .rsp_idx_o(rsp_idx)
  );

  function automatic logic [6:0] cb(int plk, int mode, int perm);
    return {2'(plk), 2'(mode), 3'(perm)};
  endfunction

  task automatic check(input string tag, input logic ev, input logic ea,
                       input logic eh, input logic [IW-1:0] ei);
    checks++;
    if (rsp_valid !== ev || rsp_allow !== ea || rsp_hit !== eh || rsp_idx !== ei) begin
      fails++;
      $display("FAIL %s: got valid=%0b allow=%0b hit=%0b idx=%0d, exp valid=%0b allow=%0b hit=%0b idx=%0d",
               tag, rsp_valid, rsp_allow, rsp_hit, rsp_idx, ev, ea, eh, ei);
    end
  endtask

  task automatic drive(input vec_t v);
    req_valid = 1'b1; level = v.lvl; req_pm = v.pm; req_kind = v.acc;
    req_wa = v.wa; closed = v.cl; mxr = v.mxr; mprv = v.mprv; mpp = v.mpp;
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_wa = '0; req_kind = 2'd0; req_pm = 1'b0;
    mxr = 1'b0; mprv = 1'b0; mpp = 2'd0; level = 2'd0; closed = 1'b0;
    cfg = '0; eaddr = '0;
    cfg[0] = cb(2, 2, 3'b001); eaddr[0] = WA_W'('h100);  // NA4
    cfg[1] = cb(0, 3, 3'b101); eaddr[1] = WA_W'('h203);  // NAPOT 0x200..0x207
    cfg[2] = cb(1, 1, 3'b110); eaddr[2] = WA_W'('h300);  // TOR 0x203..0x2FF
    cfg[3] = cb(0, 3, 3'b111); eaddr[3] = WA_W'('h107);  // NAPOT 0x100..0x10F
    cfg[4] = cb(0, 0, 3'b111); eaddr[4] = WA_W'('h400);  // OFF
    cfg[5] = cb(3, 2, 3'b100); eaddr[5] = WA_W'('h500);  // NA4
    repeat (4) @(negedge clk);
    check("R1 reset state", 1'b0, 1'b0, 1'b0, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check($sformatf("vector %0d requirement R%0d", i, VECS[i].req),
            1'b1, VECS[i].ea, VECS[i].eh, VECS[i].ei);
    end

    // R1: idle cycle keeps the last verdict (last vector: allow 1, hit 1, idx 3)
    req_valid = 1'b0; req_wa = WA_W'('h500); req_kind = 2'd1;
    @(negedge clk);
    check("R1 idle holds verdict", 1'b0, 1'b1, 1'b1, 3'd3);

    // R3: entry 0 in TOR mode starts at word 0
    cfg[0] = cb(0, 1, 3'b000); eaddr[0] = WA_W'('h10);
    drive(mk(3, 0,0,0,'h0, 0,0,0,0, 0,1,0));
    @(negedge clk);
    check("R3 TOR entry0 bottom", 1'b1, 1'b0, 1'b1, 3'd0);
    drive(mk(3, 0,1,2,'hF, 0,0,0,0, 1,1,0));
    @(negedge clk);
    check("R3 TOR entry0 top word", 1'b1, 1'b1, 1'b1, 3'd0);
    drive(mk(3, 0,1,2,'h10, 0,0,0,0, 1,0,0));
    @(negedge clk);
    check("R3 TOR entry0 exclusive end", 1'b1, 1'b1, 1'b0, 3'd0);
    req_valid = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog expired: got hung run, exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule